// File: doc/BRIEF.md
# Divider Setting Register with Parallel and Serial Load

This block holds the two settings a frequency synthesizer needs: a 6-bit feedback multiplier M and a 2-bit output-divider code N. A host can set them in two ways. It can drive them on parallel pins under an active-low parallel strobe, or it can shift them in one bit at a time over a three-wire serial port made of data, clock and load lines. Both paths write the same pair of output registers. The block also gives the decoded output ratio, an output-enable flag and a one-cycle update pulse that tells the dividers to reload.

All pins are asynchronous to the block. Every pin passes through a synchronizer clocked by the system clock, and the serial clock's rising edge is detected after synchronization. For this reason the system clock must run at least four times faster than the serial clock, and each serial clock level must last at least two system cycles. An active-high clear input empties the shift register and the settings and drops the output enable.

Top module: `divcfg_reg`

## Requirements
- R1: While `clr` is high, `m_val` and `n_code` read 0, `n_ratio` reads 1 (4'b0001), `out_en` and `cfg_upd` are low, and the shift register is empty, so a later serial transfer with no new bits produces M=0 and N=0.
- R2: One system clock after `clr` falls, `out_en` is high, and it stays high until the next clear.
- R3: While `pl_n` is low, `m_val`/`n_code` follow `par_m`/`par_n`. A pin change driven between clock edges appears on the outputs at the third rising clock edge after it and not at the second.
- R4: After `pl_n` rises, with `ser_ld` low, the outputs keep the pin values present just before the rise, and later changes on `par_m`/`par_n` have no effect.
- R5: A rising edge of `ser_clk` shifts `ser_dat` into the shift register only while `pl_n` is high. Serial clock edges that arrive while `pl_n` is low leave the register unchanged.
- R6: The serial frame is 14 bits, sent first to last: two lead bits, one spare, N[1], N[0], three spares, then M[5] down to M[0]. On the rising edge of `ser_ld` (with `pl_n` high), the last six bits shifted become M and the 10th and 11th bits from the end become N. Spare and lead bits have no effect.
- R7: After `ser_ld` falls (with `pl_n` high), the outputs hold, and further serial frames do not change them.
- R8: While `ser_ld` and `pl_n` are both high, every rising `ser_clk` edge moves the newly shifted register contents straight to `m_val`/`n_code`.
- R9: `n_ratio` is one-hot and gives the output division: code 0→1 (0001), 1→2 (0010), 2→4 (0100), 3→8 (1000).
- R10: `cfg_upd` pulses high for exactly one cycle each time `m_val` or `n_code` takes a new value. It stays low when a load writes the value already held.
- R11: While `pl_n` is low, the parallel pins win. Pulses on `ser_ld` do not change the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all pins |
| clr | input | 1 | Asynchronous active-high clear |
| pl_n | input | 1 | Parallel strobe: transparent when low, holds on its rise |
| par_m | input | 6 | Parallel M setting |
| par_n | input | 2 | Parallel N code |
| ser_clk | input | 1 | Serial shift clock (rising edge active) |
| ser_dat | input | 1 | Serial data bit |
| ser_ld | input | 1 | Serial load: transfer on rise, hold on fall, pass-through while high |
| m_val | output | 6 | Current M setting |
| n_code | output | 2 | Current N code |
| n_ratio | output | 4 | One-hot output division ratio |
| out_en | output | 1 | Output enable, low during clear |
| cfg_upd | output | 1 | One-cycle pulse when M or N changes |

## Verification
The parallel strobe and a serial event can fall in the same cycle. That happens when `ser_clk` toggles and `ser_ld` pulses while `pl_n` is held low. To provoke it, the bench first loads a frame serially. It then drops `pl_n` with new pin values, toggles the serial clock with ones and pulses the serial load. The outputs must stay on the pin values the whole time. Once `pl_n` is high again, a serial transfer must bring back the frame that was loaded earlier, which shows that the register neither shifted nor drove the outputs while the strobe was low.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
   // where the next value of the held divider setting comes from
   typedef enum logic [1:0] {
      SRC_PAR  = 2'd0,
      SRC_SER  = 2'd1,
      SRC_HOLD = 2'd2
   } src_e;
endpackage

// File: rtl/divcfg_sync.sv
module divcfg_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
)(
   input  logic         clk,
   input  logic         clr,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("divcfg_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("divcfg_sync: W must be at least 1");
   end

   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         for (int i = 0; i < STAGES; i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/divcfg_shreg.sv
module divcfg_shreg #(
   parameter int unsigned M_W      = 6,
   parameter int unsigned N_W      = 2,
   parameter int unsigned NULL_GAP = 3
)(
   input  logic           clk,
   input  logic           clr,
   input  logic           shift_en,
   input  logic           din,
   output logic [M_W-1:0] m_f,
   output logic [N_W-1:0] n_f
);
   // only the tail of the frame that reaches a field is stored; older bits fall off
   localparam int unsigned N_LSB = M_W + NULL_GAP;
   localparam int unsigned SR_W  = N_LSB + N_W;

   if (M_W < 1 || N_W < 1) begin : g_bad_fields
      $error("divcfg_shreg: field widths must be non-zero");
   end

   logic [SR_W-1:0] sr;

   always_ff @(posedge clk or posedge clr) begin
      if (clr)           sr <= '0;
      else if (shift_en) sr <= {sr[SR_W-2:0], din};
   end

   assign m_f = sr[M_W-1:0];
   assign n_f = sr[N_LSB +: N_W];

   // R5: an enabled shift moves the newest bit in at the bottom
   assert_shift_in_R5: assert property (@(posedge clk) disable iff (clr)
      shift_en |=> (sr == {$past(sr[SR_W-2:0]), $past(din)}));
   // R5: without a qualified serial clock edge the register is untouched
   assert_no_shift_R5: assert property (@(posedge clk) disable iff (clr)
      !shift_en |=> $stable(sr));
endmodule

// File: rtl/divcfg_ratio.sv
module divcfg_ratio #(
   parameter int unsigned N_W = 2
)(
   input  logic [N_W-1:0]        code,
   output logic [(1<<N_W)-1:0]   ratio
);
   localparam int unsigned RAT_W = 1 << N_W;

   if (N_W > 4) begin : g_bad_code
      $error("divcfg_ratio: N_W above 4 makes an impractical ratio vector");
   end

   for (genvar i = 0; i < RAT_W; i++) begin : g_dec
      assign ratio[i] = (code == N_W'(i));
   end
endmodule

// File: rtl/divcfg_reg.sv
module divcfg_reg import divcfg_pkg::*; #(
   parameter int unsigned M_W         = 6,
   parameter int unsigned N_W         = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned NULL_GAP    = 3
)(
   input  logic                  clk,
   input  logic                  clr,
   input  logic                  pl_n,
   input  logic [M_W-1:0]        par_m,
   input  logic [N_W-1:0]        par_n,
   input  logic                  ser_clk,
   input  logic                  ser_dat,
   input  logic                  ser_ld,
   output logic [M_W-1:0]        m_val,
   output logic [N_W-1:0]        n_code,
   output logic [(1<<N_W)-1:0]   n_ratio,
   output logic                  out_en,
   output logic                  cfg_upd
);
   localparam int unsigned SYNC_W = M_W + N_W + 4;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("divcfg_reg: at least two synchronizer stages are required");
   end

   logic [SYNC_W-1:0] raw, syncd;
   logic              pl_s, sclk_s, sdat_s, sld_s, sclk_q;
   logic [M_W-1:0]    par_m_s, sr_m, nxt_m, m_q;
   logic [N_W-1:0]    par_n_s, sr_n, nxt_n, n_q;
   logic              shift_en, upd_q, oe_q;
   src_e              src;

   assign raw = {pl_n, ser_clk, ser_dat, ser_ld, par_n, par_m};

   divcfg_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .clr (clr), .d (raw), .q (syncd)
   );

   assign {pl_s, sclk_s, sdat_s, sld_s, par_n_s, par_m_s} = syncd;

   always_ff @(posedge clk or posedge clr) begin
      if (clr) sclk_q <= 1'b0;
      else     sclk_q <= sclk_s;
   end

   // serial clock rising edge, honoured only outside parallel mode
   assign shift_en = pl_s & sclk_s & ~sclk_q;

   divcfg_shreg #(.M_W(M_W), .N_W(N_W), .NULL_GAP(NULL_GAP)) u_shreg (
      .clk (clk), .clr (clr), .shift_en (shift_en), .din (sdat_s),
      .m_f (sr_m), .n_f (sr_n)
   );

   // parallel strobe low has priority; serial load high means pass-through
   always_comb begin
      if (!pl_s)      src = SRC_PAR;
      else if (sld_s) src = SRC_SER;
      else            src = SRC_HOLD;
   end

   always_comb begin
      case (src)
         SRC_PAR: begin nxt_m = par_m_s; nxt_n = par_n_s; end
         SRC_SER: begin nxt_m = sr_m;    nxt_n = sr_n;    end
         default: begin nxt_m = m_q;     nxt_n = n_q;     end
      endcase
   end

   always_ff @(posedge clk or posedge clr) begin
      if (clr) begin
         m_q   <= '0;
         n_q   <= '0;
         upd_q <= 1'b0;
         oe_q  <= 1'b0;
      end else begin
         m_q   <= nxt_m;
         n_q   <= nxt_n;
         upd_q <= (nxt_m != m_q) || (nxt_n != n_q);
         oe_q  <= 1'b1;
      end
   end

   divcfg_ratio #(.N_W(N_W)) u_ratio (.code (n_q), .ratio (n_ratio));

   assign m_val   = m_q;
   assign n_code  = n_q;
   assign cfg_upd = upd_q;
   assign out_en  = oe_q;

   // R1: clear keeps the outputs disabled
   assert_clear_oe_R1: assert property (@(posedge clk)
      clr |-> (!out_en && m_val == '0 && n_code == '0));
   // R3: parallel mode copies the synchronized pins one cycle later
   assert_par_follow_R3: assert property (@(posedge clk) disable iff (clr)
      !pl_s |=> (m_val == $past(par_m_s) && n_code == $past(par_n_s)));
   // R4 and R7: strobe high with serial load low holds the setting
   assert_hold_R4: assert property (@(posedge clk) disable iff (clr)
      (pl_s && !sld_s) |=> ($stable(m_val) && $stable(n_code)));
   // R8: held serial load passes the shift register fields through
   assert_ser_pass_R8: assert property (@(posedge clk) disable iff (clr)
      (pl_s && sld_s) |=> (m_val == $past(sr_m) && n_code == $past(sr_n)));
   // R10: update pulse marks exactly the cycles where the setting moved
   assert_upd_pulse_R10: assert property (@(posedge clk) disable iff (clr)
      cfg_upd == ((m_val != $past(m_val)) || (n_code != $past(n_code))));
   // R9: ratio is always a single set bit
   assert_ratio_hot_R9: assert property (@(posedge clk) disable iff (clr)
      $countones(n_ratio) == 1);
endmodule

// File: tb/divcfg_reg_tb.sv
module divcfg_reg_tb;
   logic       clk = 1'b0;
   logic       clr = 1'b0;
   logic       pl_n = 1'b0;
   logic [5:0] par_m = '0;
   logic [1:0] par_n = '0;
   logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_ld = 1'b0;
   logic [5:0] m_val;
   logic [1:0] n_code;
   logic [3:0] n_ratio;
   logic       out_en, cfg_upd;

   int total = 0, bad = 0, upd_cnt = 0;
   bit done = 1'b0;
   logic [13:0] model = '0;

   always #5 clk = ~clk;

   divcfg_reg u_dut (
      .clk (clk), .clr (clr), .pl_n (pl_n), .par_m (par_m), .par_n (par_n),
      .ser_clk (ser_clk), .ser_dat (ser_dat), .ser_ld (ser_ld),
      .m_val (m_val), .n_code (n_code), .n_ratio (n_ratio),
      .out_en (out_en), .cfg_upd (cfg_upd)
   );

   always @(negedge clk) if (cfg_upd === 1'b1) upd_cnt++;

   // {M, N} pairs for the parallel walk; all four N codes appear
   localparam logic [7:0] PVEC [6] = '{
      {6'd32, 2'd0}, {6'd13, 2'd1}, {6'd63, 2'd2},
      {6'd1,  2'd3}, {6'd42, 2'd3}, {6'd0,  2'd2}
   };

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic check_cfg(input logic [5:0] m, input logic [1:0] n, input string tag);
      check({10'd0, m_val}, {10'd0, m}, tag);
      check({14'd0, n_code}, {14'd0, n}, tag);
      check({12'd0, n_ratio}, 16'd1 << n, tag);
   endtask

   task automatic ser_bit(input logic b);
      ser_dat = b;
      wait_clk(3);
      ser_clk = 1'b1;
      if (pl_n) model = {model[12:0], b};
      wait_clk(3);
      ser_clk = 1'b0;
      wait_clk(3);
   endtask

   task automatic send_frame(input logic [5:0] m, input logic [1:0] n);
      logic [13:0] f;
      f = {2'b00, 1'b1, n, 3'b111, m};
      for (int i = 13; i >= 0; i--) ser_bit(f[i]);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog act=timeout exp=completion");
         summary();
         $finish;
      end
   end

   initial begin
      #2 clr = 1'b1;
      wait_clk(3);
      // R1 reset state
      check_cfg(6'd0, 2'd0, "R1 reset value");
      check({15'd0, out_en}, 16'd0, "R1 out_en low in clear");
      check({15'd0, cfg_upd}, 16'd0, "R1 no update in clear");
      clr = 1'b0;
      wait_clk(1);
      check({15'd0, out_en}, 16'd1, "R2 out_en after clear");

      // R3, R9, R10 parallel walk
      for (int i = 0; i < 6; i++) begin
         logic [5:0] pm;
         logic [1:0] pn;
         pm = (i == 0) ? 6'd0 : PVEC[i-1][7:2];
         pn = (i == 0) ? 2'd0 : PVEC[i-1][1:0];
         upd_cnt = 0;
         par_m = PVEC[i][7:2];
         par_n = PVEC[i][1:0];
         wait_clk(2);
         check({10'd0, m_val}, {10'd0, pm}, "R3 not yet after two edges");
         wait_clk(1);
         check_cfg(PVEC[i][7:2], PVEC[i][1:0], "R3/R9 parallel follow");
         wait_clk(3);
         check(upd_cnt[15:0], 16'd1, "R10 one pulse per change");
      end

      // R4 rising strobe holds
      pl_n = 1'b1;
      wait_clk(4);
      par_m = 6'd17;
      par_n = 2'd1;
      wait_clk(5);
      check_cfg(6'd0, 2'd2, "R4 held after strobe rise");
      check({15'd0, out_en}, 16'd1, "R2 out_en stays high");

      // R10 same value rewritten: no pulse
      par_m = 6'd0;
      par_n = 2'd2;
      wait_clk(4);
      upd_cnt = 0;
      pl_n = 1'b0;
      wait_clk(6);
      check(upd_cnt[15:0], 16'd0, "R10 no pulse on equal value");
      check_cfg(6'd0, 2'd2, "R3 same value");

      // R5, R6 serial frame then transfer
      pl_n = 1'b1;
      wait_clk(5);
      send_frame(6'd37, 2'd3);
      check_cfg(6'd0, 2'd2, "R5 shifting does not move outputs");
      upd_cnt = 0;
      ser_ld = 1'b1;
      wait_clk(5);
      check_cfg(6'd37, 2'd3, "R6 transfer on load rise");
      check(upd_cnt[15:0], 16'd1, "R10 pulse on serial transfer");

      // R7 falling load holds
      ser_ld = 1'b0;
      wait_clk(5);
      send_frame(6'd5, 2'd1);
      check_cfg(6'd37, 2'd3, "R7 hold after load fall");

      // R11 and R5: parallel wins, serial clock ignored while strobe low
      par_m = 6'd20;
      par_n = 2'd0;
      pl_n = 1'b0;
      wait_clk(5);
      check_cfg(6'd20, 2'd0, "R3 parallel after serial");
      for (int k = 0; k < 4; k++) ser_bit(1'b1);
      ser_ld = 1'b1;
      wait_clk(5);
      check_cfg(6'd20, 2'd0, "R11 load high ignored in parallel");
      ser_ld = 1'b0;
      wait_clk(5);
      check_cfg(6'd20, 2'd0, "R11 load fall ignored in parallel");
      pl_n = 1'b1;
      wait_clk(5);
      ser_ld = 1'b1;
      wait_clk(5);
      check_cfg(6'd5, 2'd1, "R5 no shift while strobe low");

      // R8 pass-through with load held high
      for (int k = 0; k < 7; k++) begin
         ser_bit(k[0] ^ k[1]);
         check({10'd0, m_val}, {10'd0, model[5:0]}, "R8 pass-through M");
         check({14'd0, n_code}, {14'd0, model[10:9]}, "R8 pass-through N");
      end
      ser_bit(1'b1);
      ser_ld = 1'b0;
      wait_clk(5);

      // R1 clear mid-run, shift register emptied
      par_m = 6'd0;
      par_n = 2'd0;
      clr = 1'b1;
      wait_clk(2);
      check_cfg(6'd0, 2'd0, "R1 clear mid-run");
      check({15'd0, out_en}, 16'd0, "R1 out_en low mid-run");
      clr = 1'b0;
      model = '0;
      wait_clk(5);
      check({15'd0, out_en}, 16'd1, "R2 out_en back");
      ser_ld = 1'b1;
      wait_clk(5);
      check_cfg(6'd0, 2'd0, "R1 shift register cleared");
      ser_ld = 1'b0;
      wait_clk(2);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule